// File: doc/BRIEF.md
# Credit-Paced Flit Link

This block joins a flit transmitter to a receiver over a link with a fixed, configurable delay in each direction. The transmitter takes flits from a ready/valid source. It keeps a credit counter that starts equal to the receiver's buffer depth. It spends one credit per flit it launches and refuses the source while no credit is left. The receiver lands arriving flits in an input FIFO of that depth.

A downstream consumer can drain zero, one or two flits per cycle from the FIFO. Each cycle in which flits leave the FIFO, the receiver sends the number drained back over the return path as a credit value. The transmitter adds that value to its counter.

The consumer sees the two oldest stored flits and the stored count. It asks for a drain on a two-bit request. The link delays are parameters, so the same block covers short neighbour hops and longer pipelined wires.

Top module: `crlink_top`

## Requirements
- R1: While reset is asserted, creditCount equals DEPTH, srcReady is 1, availCount is 0 and creditErr is 0.
- R2: A flit is accepted on a clock edge where srcValid and srcReady are both 1, and each accepted flit lowers creditCount by one.
- R3: While creditCount is 0, srcReady is 0 and no flit is accepted, whatever srcValid does.
- R4: srcReady returns to 1 in the same cycle that creditCount becomes nonzero.
- R5: A credit value arriving on the return path is added to creditCount. When an arrival and an accepted flit share an edge, the new count is the old count plus the arrival minus one.
- R6: A flit accepted at edge t is stored in the FIFO at edge t+FWD_DELAY. Flits leave in acceptance order, and headData shows the oldest stored flit whenever availCount is at least 1.
- R7: drainReq encodes 0 = none, 1 = one flit, 2 = two flits, 3 = two flits. The number removed at an edge is the smaller of that request and availCount. nextData shows the second-oldest flit whenever availCount is at least 2.
- R8: The number of flits removed at edge p is returned as one credit value and is added to creditCount at edge p+BWD_DELAY.
- R9: availCount never exceeds DEPTH, and no arriving flit finds the FIFO full.
- R10: creditCount never exceeds DEPTH. If returns would push it past DEPTH, creditErr is set and stays set, and the count is held at DEPTH. In correct operation creditErr stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcValid | input | 1 | Source offers a flit |
| srcData | input | DATA_W (16) | Offered flit payload |
| srcReady | output | 1 | Transmitter holds at least one credit |
| drainReq | input | 2 | Consumer drain request: 0 none, 1 one flit, 2 or 3 two flits |
| availCount | output | $clog2(DEPTH+1) (3) | Flits stored in the receiver FIFO |
| headData | output | DATA_W (16) | Oldest stored flit |
| nextData | output | DATA_W (16) | Second-oldest stored flit |
| creditCount | output | $clog2(DEPTH+1) (3) | Transmitter credit counter |
| creditErr | output | 1 | Sticky flag: a credit return would have exceeded DEPTH |

## Verification
The bench first runs the counter all the way to zero with the source still asserting valid. A design that stalled one cycle late would overfill the FIFO. One that released the source one cycle late would show srcReady low while credits are already back.

Double drains send a two-credit value back in a single cycle. A transmitter that added only one credit per cycle would show a falling count and needless stalls.

Cycles in which a return lands on the same edge as a launch expose a counter that lets one update win over the other. Random consumer stalls mixed with over-requests (value 3, or more than is stored) check that a drain never removes flits that are not there. They also check that the returned credit matches what really left, so a miscount would either leak credits or overflow the buffer.

// File: rtl/crlink_pkg.sv
package crlink_pkg;

  // Strobes handed from the control module to the datapath each cycle
  typedef struct packed {
    logic       sendFlit;  // launch the source flit onto the forward link
    logic [1:0] popCnt;    // flits removed from the receiver FIFO
  } linkStrobe_t;

endpackage

// File: rtl/crlink_ctrl.sv
module crlink_ctrl
  import crlink_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            srcValid,
  input  logic [1:0]                      drainReq,
  input  logic [$clog2(DEPTH+1)-1:0]      occ,
  input  logic [1:0]                      retCredit,
  output linkStrobe_t                     strb,
  output logic                            srcReady,
  output logic [$clog2(DEPTH+1)-1:0]      creditCount,
  output logic                            creditErr
);

  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0] creditCnt;
  logic             errFlag;
  logic             sendNow;
  logic [1:0]       reqCnt;
  logic [1:0]       popCnt;
  int               sumNext;

  // Transmit side: spend a credit per launched flit
  always_comb begin
    sendNow = srcValid && (creditCnt != '0);
    sumNext = int'(creditCnt) + int'(retCredit) - int'(sendNow);
  end

  // Receive side: clamp the consumer request to what is stored
  always_comb begin
    reqCnt = (drainReq == 2'd3) ? 2'd2 : drainReq;
    if (CNT_W'(reqCnt) > occ) popCnt = occ[1:0];
    else                      popCnt = reqCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      creditCnt <= CNT_W'(DEPTH);
      errFlag   <= 1'b0;
    end else if (sumNext > DEPTH) begin
      creditCnt <= CNT_W'(DEPTH);
      errFlag   <= 1'b1;
    end else begin
      creditCnt <= CNT_W'(sumNext);
    end
  end

  assign strb.sendFlit = sendNow;
  assign strb.popCnt   = popCnt;
  assign srcReady      = (creditCnt != '0);
  assign creditCount   = creditCnt;
  assign creditErr     = errFlag;

  // R10
  credit_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    creditCnt <= CNT_W'(DEPTH));

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (creditCnt == '0 && retCredit == 2'd0) |=> (creditCnt == '0));

  // R5
  credit_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !errFlag |=> (errFlag || int'(creditCnt) ==
      int'($past(creditCnt)) + int'($past(retCredit)) - int'($past(strb.sendFlit))));

endmodule

// File: rtl/crlink_dpath.sv
module crlink_dpath
  import crlink_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 4,
  parameter int FWD_DELAY = 2,
  parameter int BWD_DELAY = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  linkStrobe_t                 strb,
  input  logic [DATA_W-1:0]           srcData,
  output logic [$clog2(DEPTH+1)-1:0]  occ,
  output logic [DATA_W-1:0]           headData,
  output logic [DATA_W-1:0]           nextData,
  output logic [1:0]                  retCredit
);

  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // Forward link delay line
  logic              fwdVld [FWD_DELAY];
  logic [DATA_W-1:0] fwdDat [FWD_DELAY];
  // Return link delay line
  logic [1:0]        bwdCred [BWD_DELAY];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < FWD_DELAY; i++) begin
        fwdVld[i] <= 1'b0;
        fwdDat[i] <= '0;
      end
    end else begin
      fwdVld[0] <= strb.sendFlit;
      fwdDat[0] <= srcData;
      for (int i = 1; i < FWD_DELAY; i++) begin
        fwdVld[i] <= fwdVld[i-1];
        fwdDat[i] <= fwdDat[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BWD_DELAY; i++) bwdCred[i] <= 2'd0;
    end else begin
      bwdCred[0] <= strb.popCnt;
      for (int i = 1; i < BWD_DELAY; i++) bwdCred[i] <= bwdCred[i-1];
    end
  end

  logic              arrive;
  logic [DATA_W-1:0] arriveDat;
  assign arrive    = fwdVld[FWD_DELAY-1];
  assign arriveDat = fwdDat[FWD_DELAY-1];
  assign retCredit = bwdCred[BWD_DELAY-1];

  // Receiver FIFO as a circular buffer
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  occCnt;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] ptr, input int step);
    int t;
    t = int'(ptr) + step;
    if (t >= DEPTH) t = t - DEPTH;
    return PTR_W'(t);
  endfunction

  always_ff @(posedge clk) begin
    if (arrive) mem[wrPtr] <= arriveDat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      occCnt <= '0;
    end else begin
      if (arrive) wrPtr <= advance(wrPtr, 1);
      rdPtr  <= advance(rdPtr, int'(strb.popCnt));
      occCnt <= occCnt + CNT_W'(arrive) - CNT_W'(strb.popCnt);
    end
  end

  assign occ      = occCnt;
  assign headData = mem[rdPtr];
  assign nextData = mem[advance(rdPtr, 1)];

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrive |-> (int'(occCnt) - int'(strb.popCnt) < DEPTH));

  // R7
  pop_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(strb.popCnt) <= int'(occCnt));

endmodule

// File: rtl/crlink_top.sv
module crlink_top
  import crlink_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 4,
  parameter int FWD_DELAY = 2,
  parameter int BWD_DELAY = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        srcValid,
  input  logic [DATA_W-1:0]           srcData,
  output logic                        srcReady,
  input  logic [1:0]                  drainReq,
  output logic [$clog2(DEPTH+1)-1:0]  availCount,
  output logic [DATA_W-1:0]           headData,
  output logic [DATA_W-1:0]           nextData,
  output logic [$clog2(DEPTH+1)-1:0]  creditCount,
  output logic                        creditErr
);

  localparam int CNT_W = $clog2(DEPTH+1);

  linkStrobe_t      strb;
  logic [CNT_W-1:0] occ;
  logic [1:0]       retCredit;

  crlink_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .srcValid    (srcValid),
    .drainReq    (drainReq),
    .occ         (occ),
    .retCredit   (retCredit),
    .strb        (strb),
    .srcReady    (srcReady),
    .creditCount (creditCount),
    .creditErr   (creditErr)
  );

  crlink_dpath #(
    .DATA_W    (DATA_W),
    .DEPTH     (DEPTH),
    .FWD_DELAY (FWD_DELAY),
    .BWD_DELAY (BWD_DELAY)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .srcData   (srcData),
    .occ       (occ),
    .headData  (headData),
    .nextData  (nextData),
    .retCredit (retCredit)
  );

  assign availCount = occ;

endmodule

// File: tb/crlink_top_bench.sv
`timescale 1ns/1ps
module crlink_top_bench;

  localparam int DATA_W = 16;
  localparam int DEPTH  = 4;
  localparam int FWD    = 2;
  localparam int BWD    = 3;
  localparam int CNT_W  = $clog2(DEPTH+1);

  logic              clk = 1'b0;
  logic              rstN;
  logic              srcValid;
  logic [DATA_W-1:0] srcData;
  logic              srcReady;
  logic [1:0]        drainReq;
  logic [CNT_W-1:0]  availCount;
  logic [DATA_W-1:0] headData;
  logic [DATA_W-1:0] nextData;
  logic [CNT_W-1:0]  creditCount;
  logic              creditErr;

  always #4 clk = ~clk;

  crlink_top #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FWD_DELAY(FWD), .BWD_DELAY(BWD)) u_crlink_top (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcData(srcData), .srcReady(srcReady),
    .drainReq(drainReq), .availCount(availCount), .headData(headData), .nextData(nextData),
    .creditCount(creditCount), .creditErr(creditErr)
  );

  int totalCnt = 0;
  int passCnt  = 0;

  // Behavioural reference model
  int mCred;
  int mFifo[$];
  int flitDue[$];
  int flitVal[$];
  int credDue[$];
  int credAmt[$];
  int cyc;
  int seqVal = 1;

  always @(posedge clk) begin
    int ret;
    int req;
    int pops;
    bit snd;
    if (!rstN) begin
      mCred = DEPTH;
      mFifo.delete(); flitDue.delete(); flitVal.delete();
      credDue.delete(); credAmt.delete();
      cyc = 0;
    end else begin
      ret = 0;
      while (credDue.size() > 0 && credDue[0] == cyc) begin
        ret += credAmt[0];
        void'(credDue.pop_front()); void'(credAmt.pop_front());
      end
      snd  = srcValid && (mCred > 0);
      req  = (drainReq == 2'd3) ? 2 : int'(drainReq);
      pops = (req < mFifo.size()) ? req : mFifo.size();
      for (int k = 0; k < pops; k++) void'(mFifo.pop_front());
      while (flitDue.size() > 0 && flitDue[0] == cyc) begin
        mFifo.push_back(flitVal[0]);
        void'(flitDue.pop_front()); void'(flitVal.pop_front());
      end
      mCred = mCred - int'(snd) + ret;
      if (snd) begin
        flitDue.push_back(cyc + FWD);
        flitVal.push_back(int'(srcData));
        seqVal++;
      end
      if (pops > 0) begin
        credDue.push_back(cyc + BWD);
        credAmt.push_back(pops);
      end
      cyc++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
  endtask

  task automatic compareAll();
    chk(srcReady == (mCred > 0), "R3 R4 srcReady", int'(srcReady), int'(mCred > 0));
    chk(int'(creditCount) == mCred, "R2 R5 R8 creditCount", int'(creditCount), mCred);
    chk(int'(availCount) == mFifo.size(), "R6 R7 availCount", int'(availCount), mFifo.size());
    if (mFifo.size() >= 1)
      chk(int'(headData) == mFifo[0], "R6 headData", int'(headData), mFifo[0]);
    if (mFifo.size() >= 2)
      chk(int'(nextData) == mFifo[1], "R7 nextData", int'(nextData), mFifo[1]);
    chk(creditErr == 1'b0, "R10 creditErr", int'(creditErr), 0);
    chk(int'(availCount) <= DEPTH, "R9 occupancy bound", int'(availCount), DEPTH);
  endtask

  task automatic step(input bit v, input logic [1:0] d);
    srcValid = v;
    srcData  = DATA_W'(seqVal);
    drainReq = d;
    @(negedge clk);
    compareAll();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", passCnt, totalCnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    totalCnt++;
    $display("FAIL R6 watchdog expired: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; srcValid = 1'b1; srcData = '0; drainReq = 2'd3;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(int'(creditCount) == DEPTH, "R1 creditCount", int'(creditCount), DEPTH);
    chk(srcReady == 1'b1, "R1 srcReady", int'(srcReady), 1);
    chk(availCount == '0, "R1 availCount", int'(availCount), 0);
    chk(creditErr == 1'b0, "R1 creditErr", int'(creditErr), 0);
    rstN = 1'b1;
    // R3: exhaust credits with no drain, source keeps asserting valid
    for (int i = 0; i < 12; i++) step(1'b1, 2'd0);
    // R4 R8: single drains bring credits back one at a time
    for (int i = 0; i < 8; i++) step(1'b1, 2'd1);
    // R5 R7: double drains return two credits per cycle
    for (int i = 0; i < 12; i++) step(1'b1, 2'd2);
    // R7: request encoding 3 with an idle source
    for (int i = 0; i < 8; i++) step(1'b0, 2'd3);
    // Random traffic with consumer stall bursts
    for (int i = 0; i < 3000; i++) begin
      bit stallBurst;
      stallBurst = ((i / 40) % 3) == 1;
      step(($urandom % 4) != 0, stallBurst ? 2'd0 : 2'($urandom % 4));
    end
    // Drain out and idle: credits return to full depth
    for (int i = 0; i < 20; i++) step(1'b0, 2'd2);
    chk(int'(creditCount) == DEPTH, "R8 final credits", int'(creditCount), DEPTH);
    summary();
    $finish;
  end

endmodule